// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port synchronous memory with a shared data bus. The bus is split into separate in, out and output-enable signals so that a pad ring or a bus fabric can build the tri-state. Every control input is sampled on the rising clock edge. Read data flows combinationally out of the array during the cycle that follows the edge on which the read address was taken. Write data and its per-lane enables arrive one edge later than the write address. That same edge can already start the next access, so reads and writes alternate on every clock with no idle cycle between them.

A new access starts only when the clock enable is asserted (low), all three chip selects are active and the load/advance input is low. The write enable picks the direction. With load/advance high, an open access keeps going at the next address inside an aligned group of four words. An asserted-high clock enable freezes the whole block. The asynchronous output enable gates the data drivers only during a read data phase.

Top module: `zt_sram`

## Requirements
- R1: After reset the block is deselected and `dq_oe` is 0, whatever `oe_n` is.
- R2: A read starts on an edge with `cke_n`=0, `sel0_n`=0, `sel1`=1, `sel2_n`=0, `ld_n`=0 and `we_n`=1. During the following cycle `dq_o` holds the word stored at the sampled address.
- R3: A write starts on the same conditions with `we_n`=0. On the next unstalled edge, each lane i (bits 9i+8 down to 9i of `dq_i`) is stored only if `bw_n[i]`=0. The other lanes keep their old contents. Any mix of lane enables is legal.
- R4: A write with all four `bw_n` bits high changes no stored data.
- R5: An edge with `ld_n`=0 and any chip select inactive deselects the block, and `dq_oe` is 0 in the next cycle. Further edges with `ld_n`=1 keep it deselected.
- R6: An edge with `cke_n`=1 changes no state and performs no write. The output word and the current phase carry over unchanged.
- R7: `dq_oe` is 0 during the data phase of any write, even with `oe_n`=0.
- R8: During a read data phase, `dq_oe` follows `oe_n` inverted at once, with no clock edge needed.
- R9: A read issued on the edge that captures write data for the same address returns the merged new word in the next cycle. A write may start on the edge right after a read address, with no dead cycle in either order.
- R10: An edge with `ld_n`=1 during an open access moves the address to the next word, counting up in the two low address bits with wrap-around. The access type stays the same, and the chip selects and `we_n` are ignored on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high freezes the block |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low loads a new access, high advances the open one |
| we_n | input | 1 | Write enable, active low, sampled when loading |
| addr | input | AW | Word address |
| bw_n | input | LANES | Lane write enables, active low, sampled in the write data phase |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANE*LANES | Write data from the bus |
| dq_o | output | LANE*LANES | Read data to the bus |
| dq_oe | output | 1 | Drive enable for the bus |

## Verification
The bench uses the default parameters: six address bits and four 9-bit lanes. This gives a 36-bit word, so lane masks can be checked bit for bit. A burst starting at word 10 wraps to word 8 and reaches word 9, which makes the two-bit wrap visible. The directed tasks place writes and reads on neighbouring edges in both orders. They also insert stalls inside both a read and a write data phase, and toggle the output enable without a clock edge.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW    = 6,
  parameter int LANE  = 9,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cke_n,
  input  logic                  sel0_n,
  input  logic                  sel1,
  input  logic                  sel2_n,
  input  logic                  ld_n,
  input  logic                  we_n,
  input  logic [AW-1:0]         addr,
  input  logic [LANES-1:0]      bw_n,
  input  logic                  oe_n,
  input  logic [LANE*LANES-1:0] dq_i,
  output logic [LANE*LANES-1:0] dq_o,
  output logic                  dq_oe
);
  localparam int DW    = LANE * LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          act;
  logic          wr;
  logic [AW-1:0] cur;
  logic          chip_on;

  assign chip_on = !sel0_n && sel1 && !sel2_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0;
      wr  <= 1'b0;
      cur <= '0;
    end else if (!cke_n) begin
      if (!ld_n) begin
        act <= chip_on;
        wr  <= !we_n;
        cur <= addr;
      end else if (act) begin
        cur[1:0] <= cur[1:0] + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !cke_n && act && wr) begin
      for (int i = 0; i < LANES; i++) begin
        if (!bw_n[i]) mem[cur][i*LANE +: LANE] <= dq_i[i*LANE +: LANE];
      end
    end
  end

  assign dq_o  = mem[cur];
  assign dq_oe = act && !wr && !oe_n;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic          sel0_n,
  input logic          sel1,
  input logic          sel2_n,
  input logic          ld_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe
);
  logic on;
  assign on = !sel0_n && sel1 && !sel2_n;

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !dq_oe);

  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && !on) |=> !dq_oe);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(dq_o));

  p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && on && !we_n) |=> !dq_oe);

  p_read_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && on && we_n) |=> (dq_oe == !oe_n));
endmodule

bind zt_sram zt_sram_chk #(.DW(LANE * LANES)) u_chk (.*);

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_n = 1'b0, sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic ld_n = 1'b0, we_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] bw_n = 4'hF;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [DW-1:0] D5  = 36'h1_2345_6789;
  localparam logic [DW-1:0] A7  = 36'hA_AAAA_AAAA;
  localparam logic [DW-1:0] B7  = 36'h5_5555_5555;
  localparam logic [DW-1:0] M02 = {9'h0, 9'h1FF, 9'h0, 9'h1FF};
  localparam logic [DW-1:0] E7  = (B7 & M02) | (A7 & ~M02);

  always #10 clk = ~clk;

  zt_sram #(.AW(AW), .LANE(9), .LANES(4)) u_zt_sram (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .ld_n(ld_n), .we_n(we_n), .addr(addr), .bw_n(bw_n),
    .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe));

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cmd_sel(input logic s0n, input logic s1, input logic s2n);
    ld_n = 1'b0; sel0_n = s0n; sel1 = s1; sel2_n = s2n;
  endtask

  task automatic cmd_rd(input logic [AW-1:0] a);
    cmd_sel(1'b0, 1'b1, 1'b0); we_n = 1'b1; addr = a;
  endtask

  task automatic cmd_wr(input logic [AW-1:0] a);
    cmd_sel(1'b0, 1'b1, 1'b0); we_n = 1'b0; addr = a;
  endtask

  task automatic cmd_ds();
    cmd_sel(1'b1, 1'b0, 1'b1); we_n = 1'b1; addr = '0;
  endtask

  task automatic cmd_adv();
    ld_n = 1'b1; sel0_n = 1'b1; sel1 = 1'b0; sel2_n = 1'b1; we_n = ~we_n; addr = ~addr;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; oe_n = 1'b0;
    repeat (3) step();
    chk("R1 reset drive", {35'd0, dq_oe}, 36'd0);
    rst_n = 1'b1; cmd_ds();
    step();
    chk("R1 idle after reset", {35'd0, dq_oe}, 36'd0);
  endtask

  task automatic t_write_read();
    cmd_wr(5); step();
    chk("R7 write phase drive", {35'd0, dq_oe}, 36'd0);
    dq_i = D5; bw_n = 4'h0; cmd_rd(5); step();
    chk("R2 read drive", {35'd0, dq_oe}, 36'd1);
    chk("R9 read after write", dq_o, D5);
    cmd_ds(); bw_n = 4'hF; step();
    chk("R5 deselect", {35'd0, dq_oe}, 36'd0);
  endtask

  task automatic t_lanes();
    cmd_wr(7); step();
    dq_i = A7; bw_n = 4'h0; cmd_wr(7); step();
    dq_i = B7; bw_n = 4'b1010; cmd_rd(7); step();
    chk("R3 lane merge", dq_o, E7);
    cmd_ds(); bw_n = 4'hF; step();
  endtask

  task automatic t_abort();
    cmd_wr(7); step();
    dq_i = 36'hF_0F0F_0F0F; bw_n = 4'hF; cmd_rd(7); step();
    chk("R4 write abort", dq_o, E7);
    cmd_ds(); step();
  endtask

  task automatic t_stall();
    cmd_rd(5); step();
    chk("R2 read word", dq_o, D5);
    cke_n = 1'b1; cmd_wr(7); dq_i = 36'h0_0000_0001; bw_n = 4'h0; step();
    chk("R6 stalled read data", dq_o, D5);
    chk("R6 stalled read drive", {35'd0, dq_oe}, 36'd1);
    step();
    chk("R6 second stall", dq_o, D5);
    cke_n = 1'b0; cmd_ds(); bw_n = 4'hF; step();
    cmd_wr(9); step();
    dq_i = 36'h3_3333_3333; bw_n = 4'h0; cke_n = 1'b1; cmd_rd(9); step();
    chk("R6 stall keeps write phase", {35'd0, dq_oe}, 36'd0);
    cke_n = 1'b0; dq_i = 36'hC_CCCC_CCCC; step();
    chk("R6 write after stall", dq_o, 36'hC_CCCC_CCCC);
    cmd_rd(7); bw_n = 4'hF; step();
    chk("R6 stalled write had no effect", dq_o, E7);
    cmd_ds(); step();
  endtask

  task automatic t_oe_and_deselect();
    cmd_rd(5); step();
    oe_n = 1'b1; #1;
    chk("R8 oe high", {35'd0, dq_oe}, 36'd0);
    oe_n = 1'b0; #1;
    chk("R8 oe low", {35'd0, dq_oe}, 36'd1);
    for (int k = 0; k < 3; k++) begin
      cmd_rd(5); step();
      if (k == 0) cmd_sel(1'b1, 1'b1, 1'b0);
      else if (k == 1) cmd_sel(1'b0, 1'b0, 1'b0);
      else cmd_sel(1'b0, 1'b1, 1'b1);
      step();
      chk("R5 single select off", {35'd0, dq_oe}, 36'd0);
    end
    ld_n = 1'b1; sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0; we_n = 1'b1;
    step(); step();
    chk("R5 continue deselect", {35'd0, dq_oe}, 36'd0);
    cmd_ds(); step();
  endtask

  task automatic t_war();
    cmd_rd(5); step();
    chk("R9 read before write", dq_o, D5);
    cmd_wr(12); step();
    chk("R9 write right after read", {35'd0, dq_oe}, 36'd0);
    dq_i = 36'h7_1234_5678; bw_n = 4'h0; cmd_rd(12); step();
    chk("R9 new word", dq_o, 36'h7_1234_5678);
    cmd_ds(); bw_n = 4'hF; step();
  endtask

  task automatic t_burst();
    cmd_wr(10); step();
    bw_n = 4'h0; dq_i = 36'h0_0000_000A; cmd_adv(); step();
    dq_i = 36'h0_0000_000B; step();
    dq_i = 36'h0_0000_0008; step();
    dq_i = 36'h0_0000_0009; cmd_ds(); step();
    bw_n = 4'hF;
    cmd_rd(11); step();
    chk("R10 burst first", dq_o, 36'h0_0000_000B);
    cmd_adv(); step();
    chk("R10 burst wrap", dq_o, 36'h0_0000_0008);
    step();
    chk("R10 burst third", dq_o, 36'h0_0000_0009);
    step();
    chk("R10 burst fourth", dq_o, 36'h0_0000_000A);
    chk("R10 burst stays read", {35'd0, dq_oe}, 36'd1);
    cmd_ds(); step();
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_lanes();
    t_abort();
    t_stall();
    t_oe_and_deselect();
    t_war();
    t_burst();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule